// File: doc/BRIEF.md
# Secure Session Privilege Tracker

This block follows the access privileges held by one host session on a secure memory whose user area is split into several zones. It keeps three pieces of session state: the communication mode (standard, authenticated or encrypted), the one password set that is currently accepted, and the result of the latest authentication. Outside logic does the cryptography, compares password values and stores data; it reports each result to this block as a one-cycle pulse.

Each zone's access rules are fixed by parameters. A zone may need a password for reading, a password for writing, authentication under one of the key sets, and encryption under one of the key sets. From the registered session state the block drives one read-grant flag and one write-grant flag for each zone, together with the current mode. Each password set and each key set has an attempt counter. Once a counter reaches its limit, every later attempt on that set fails, whatever value is supplied.

Top module: `sess_priv_tracker`

## Requirements
- R1: After `rst_n` is held low at a clock edge, the mode is standard (code 0), no password or authentication is held, and every attempt counter is zero. With the default zone rules, `rd_grant` is 4'b0011 and `wr_grant` is 4'b0001.
- R2: An authentication pulse that is accepted sets the mode to authenticated (code 1) and records its key. Any authentication attempt that is not accepted clears the earlier authentication and any encryption, and the mode becomes standard.
- R3: An encryption activation pulse moves the mode to encrypted (code 2) only while an authentication is held. In standard mode the pulse has no effect.
- R4: Only one password set is held at a time. An accepted presentation replaces the held set. A presentation that fails or is not accepted leaves no password held.
- R5: A held write password grants read and write on the zones bound to its set. A held read password grants read only.
- R6: A zone that needs authentication is granted only while authentication with that zone's key is held. A zone that needs encryption is granted only in encrypted mode when the authenticated key equals that zone's encryption key.
- R7: A MAC mismatch pulse clears authentication and encryption, and the mode returns to standard on the next cycle. The held password is kept. In standard mode the pulse changes nothing.
- R8: Every failed attempt raises that set's or key's counter, which stops at the limit (default 4). An accepted attempt clears the counter. At the limit, a pass pulse is handled as a failure.
- R9: A card reset pulse clears the held password, authentication and encryption. The attempt counters keep their values.
- R10: The grant and mode outputs depend only on registered state. A pulse therefore first affects them after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| card_rst | input | 1 | Card reset pulse; drops session privileges |
| pw_ok | input | 1 | Password comparison passed |
| pw_fail | input | 1 | Password comparison failed |
| pw_set | input | 3 | Password set index of the attempt |
| pw_wr | input | 1 | 1 = write password, 0 = read password |
| au_ok | input | 1 | Authentication passed |
| au_fail | input | 1 | Authentication failed |
| au_key | input | 2 | Key set index of the authentication |
| enc_go | input | 1 | Encryption activation request |
| mac_bad | input | 1 | MAC mismatch on an incoming command |
| mode | output | 2 | 0 standard, 1 authenticated, 2 encrypted |
| rd_grant | output | 4 | Per-zone read grant |
| wr_grant | output | 4 | Per-zone write grant |

## Verification
The bench drives the counters to exactly one below the limit and then to the limit. A design with an off-by-one would either lock a set one attempt early or accept a pass on a set that should be locked. It checks that a failed re-authentication drops an authentication that was valid, and that an encryption request in standard mode is ignored. A design that got either wrong would keep granting zones it should refuse. It also checks that a MAC mismatch drops authentication but keeps the password, and that a card reset keeps a locked counter locked. Mixing up those two kinds of reset would either wipe the password or let a card reset unlock the counters.

// File: rtl/sess_pkg.sv
// Shared types for the session privilege tracker.
package sess_pkg;
    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_AUTH = 2'd1,
        MODE_ENC  = 2'd2
    } mode_e;
endpackage

// File: rtl/sess_trial_bank.sv
// Bank of saturating attempt counters, one per password set or key set.
// Decides whether a pass pulse is accepted: an entry whose counter has reached
// LIMIT refuses every pass. Assumes at most one attempt per cycle.
module sess_trial_bank #(
    parameter int NSET  = 8,
    parameter int LIMIT = 4,
    localparam int IW   = (NSET > 1) ? $clog2(NSET) : 1,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          try_v,
    input  logic          try_ok,
    input  logic [IW-1:0] try_idx,
    output logic          accept
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt [NSET];

    // Accept a pass only while the addressed counter is below the limit.
    always_comb accept = try_v && try_ok && (cnt[try_idx] < LIM);

    generate
        for (genvar i = 0; i < NSET; i++) begin : g_ctr
            // Per-entry counter: clear on accepted pass, otherwise count up to LIMIT.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt[i] <= '0;
                end else if (try_v && (try_idx == IW'(i))) begin
                    if (accept)
                        cnt[i] <= '0;
                    else if (cnt[i] != LIM)
                        cnt[i] <= cnt[i] + 1'b1;
                end
            end

            AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
                cnt[i] <= LIM);  // R8
            AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt[i] == LIM) |=> (cnt[i] == LIM)); // R8
        end
    endgenerate
endmodule

// File: rtl/sess_pw_track.sv
// Holds the single active password set and its read/write kind.
// Assumes acceptance is decided by the trial bank.
module sess_pw_track #(
    parameter int NPWSET = 8,
    localparam int SW    = $clog2(NPWSET)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_rst,
    input  logic          try_v,
    input  logic          accept,
    input  logic [SW-1:0] try_set,
    input  logic          try_wr,
    output logic          pw_valid,
    output logic [SW-1:0] pw_idx,
    output logic          pw_is_wr
);
    // Active password register: replaced on accept, dropped on any other attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || card_rst) begin
            pw_valid <= 1'b0;
            pw_idx   <= '0;
            pw_is_wr <= 1'b0;
        end else if (try_v) begin
            pw_valid <= accept;
            pw_idx   <= try_set;
            pw_is_wr <= try_wr;
        end
    end

    AST_PW_FAIL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (try_v && !accept) |=> !pw_valid); // R4
    AST_CARD_RST_PW: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> !pw_valid); // R9
endmodule

// File: rtl/sess_auth_track.sv
// Holds the authentication result and the encryption state; derives the mode.
// Event priority: card reset, authentication attempt, MAC mismatch, encryption.
module sess_auth_track
    import sess_pkg::*;
#(
    parameter int NKEY = 4,
    localparam int KW  = $clog2(NKEY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_rst,
    input  logic          au_try,
    input  logic          au_accept,
    input  logic [KW-1:0] au_key,
    input  logic          enc_go,
    input  logic          mac_bad,
    output logic          auth_valid,
    output logic [KW-1:0] auth_key,
    output mode_e         mode_o
);
    logic enc_on;

    // Session security state update by event priority.
    always_ff @(posedge clk) begin
        if (!rst_n || card_rst) begin
            auth_valid <= 1'b0;
            auth_key   <= '0;
            enc_on     <= 1'b0;
        end else if (au_try) begin
            auth_valid <= au_accept;
            auth_key   <= au_key;
            enc_on     <= 1'b0;
        end else if (mac_bad) begin
            auth_valid <= 1'b0;
            enc_on     <= 1'b0;
        end else if (enc_go && auth_valid) begin
            enc_on     <= 1'b1;
        end
    end

    // Mode decode from the registered flags.
    always_comb begin
        if (enc_on)          mode_o = MODE_ENC;
        else if (auth_valid) mode_o = MODE_AUTH;
        else                 mode_o = MODE_STD;
    end

    AST_ENC_NEEDS_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_ENC) |-> auth_valid); // R3
    AST_STD_ENC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MODE_STD) && enc_go && !au_try) |=> (mode_o != MODE_ENC)); // R3
    AST_MAC_REVOKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_bad && !au_try && !card_rst) |=> (mode_o == MODE_STD)); // R7
    AST_AUTH_FAIL_STD: assert property (@(posedge clk) disable iff (!rst_n)
        (au_try && !au_accept) |=> (mode_o == MODE_STD)); // R2
endmodule

// File: rtl/sess_zone_grant.sv
// Per-zone grant logic: combines zone rules (parameters) with session state.
// Purely combinational; assumes its inputs are registered upstream.
module sess_zone_grant
    import sess_pkg::*;
#(
    parameter int NZONE  = 4,
    parameter int NPWSET = 8,
    parameter int NKEY   = 4,
    parameter logic [NZONE-1:0]                    ZONE_RD_PW   = '0,
    parameter logic [NZONE-1:0]                    ZONE_WR_PW   = '0,
    parameter logic [NZONE*$clog2(NPWSET)-1:0]     ZONE_PW_SET  = '0,
    parameter logic [NZONE-1:0]                    ZONE_AUTH    = '0,
    parameter logic [NZONE*$clog2(NKEY)-1:0]       ZONE_AUTH_KEY = '0,
    parameter logic [NZONE-1:0]                    ZONE_ENC     = '0,
    parameter logic [NZONE*$clog2(NKEY)-1:0]       ZONE_ENC_KEY = '0,
    localparam int SW = $clog2(NPWSET),
    localparam int KW = $clog2(NKEY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pw_valid,
    input  logic [SW-1:0]    pw_idx,
    input  logic             pw_is_wr,
    input  logic             auth_valid,
    input  logic [KW-1:0]    auth_key,
    input  mode_e            mode_i,
    output logic [NZONE-1:0] rd_grant,
    output logic [NZONE-1:0] wr_grant
);
    generate
        for (genvar z = 0; z < NZONE; z++) begin : g_zone
            logic set_hit, pw_rd, pw_wr, sec_ok;

            // Password, authentication and encryption conditions for this zone.
            always_comb begin
                set_hit = pw_valid && (pw_idx == ZONE_PW_SET[z*SW +: SW]);
                pw_rd   = !ZONE_RD_PW[z] || set_hit;
                pw_wr   = !ZONE_WR_PW[z] || (set_hit && pw_is_wr);
                sec_ok  = (!ZONE_AUTH[z] ||
                           (auth_valid && auth_key == ZONE_AUTH_KEY[z*KW +: KW])) &&
                          (!ZONE_ENC[z] ||
                           (mode_i == MODE_ENC && auth_key == ZONE_ENC_KEY[z*KW +: KW]));
                rd_grant[z] = pw_rd && sec_ok;
                wr_grant[z] = pw_wr && sec_ok;
            end

            if (ZONE_ENC[z]) begin : g_enc_chk
                AST_ENC_ZONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_grant[z] || wr_grant[z]) |-> (mode_i == MODE_ENC)); // R6
            end
            if (ZONE_AUTH[z]) begin : g_auth_chk
                AST_AUTH_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
                    rd_grant[z] |-> auth_valid); // R6
            end
        end
    endgenerate
endmodule

// File: rtl/sess_priv_tracker.sv
// Top level: session privilege tracker for a multi-zone secure memory.
// Inputs are one-cycle result pulses from the crypto and comparison logic;
// outputs are per-zone grants and the mode, all decoded from registered state.
module sess_priv_tracker
    import sess_pkg::*;
#(
    parameter int NZONE    = 4,
    parameter int NPWSET   = 8,
    parameter int NKEY     = 4,
    parameter int PW_LIMIT = 4,
    parameter int AU_LIMIT = 4,
    parameter logic [NZONE-1:0]                ZONE_RD_PW    = 4'b0100,
    parameter logic [NZONE-1:0]                ZONE_WR_PW    = 4'b0110,
    parameter logic [NZONE*$clog2(NPWSET)-1:0] ZONE_PW_SET   = 12'h0C8,
    parameter logic [NZONE-1:0]                ZONE_AUTH     = 4'b1100,
    parameter logic [NZONE*$clog2(NKEY)-1:0]   ZONE_AUTH_KEY = 8'h60,
    parameter logic [NZONE-1:0]                ZONE_ENC      = 4'b1000,
    parameter logic [NZONE*$clog2(NKEY)-1:0]   ZONE_ENC_KEY  = 8'h40,
    localparam int SW = $clog2(NPWSET),
    localparam int KW = $clog2(NKEY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_rst,
    input  logic             pw_ok,
    input  logic             pw_fail,
    input  logic [SW-1:0]    pw_set,
    input  logic             pw_wr,
    input  logic             au_ok,
    input  logic             au_fail,
    input  logic [KW-1:0]    au_key,
    input  logic             enc_go,
    input  logic             mac_bad,
    output logic [1:0]       mode,
    output logic [NZONE-1:0] rd_grant,
    output logic [NZONE-1:0] wr_grant
);
    logic          pw_try, pw_pass, pw_accept;
    logic          au_try, au_pass, au_accept;
    logic          pw_valid, pw_is_wr, auth_valid;
    logic [SW-1:0] pw_idx;
    logic [KW-1:0] auth_key;
    mode_e         mode_w;

    // Attempt decode; a card reset cancels any attempt in the same cycle.
    always_comb begin
        pw_try  = (pw_ok || pw_fail) && !card_rst;
        pw_pass = pw_ok && !pw_fail;
        au_try  = (au_ok || au_fail) && !card_rst;
        au_pass = au_ok && !au_fail;
    end

    sess_trial_bank #(.NSET(NPWSET), .LIMIT(PW_LIMIT)) u_pw_trials (
        .clk(clk), .rst_n(rst_n), .try_v(pw_try), .try_ok(pw_pass),
        .try_idx(pw_set), .accept(pw_accept)
    );

    sess_trial_bank #(.NSET(NKEY), .LIMIT(AU_LIMIT)) u_au_trials (
        .clk(clk), .rst_n(rst_n), .try_v(au_try), .try_ok(au_pass),
        .try_idx(au_key), .accept(au_accept)
    );

    sess_pw_track #(.NPWSET(NPWSET)) u_pw (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .try_v(pw_try),
        .accept(pw_accept), .try_set(pw_set), .try_wr(pw_wr),
        .pw_valid(pw_valid), .pw_idx(pw_idx), .pw_is_wr(pw_is_wr)
    );

    sess_auth_track #(.NKEY(NKEY)) u_auth (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .au_try(au_try),
        .au_accept(au_accept), .au_key(au_key), .enc_go(enc_go),
        .mac_bad(mac_bad), .auth_valid(auth_valid), .auth_key(auth_key),
        .mode_o(mode_w)
    );

    sess_zone_grant #(
        .NZONE(NZONE), .NPWSET(NPWSET), .NKEY(NKEY),
        .ZONE_RD_PW(ZONE_RD_PW), .ZONE_WR_PW(ZONE_WR_PW),
        .ZONE_PW_SET(ZONE_PW_SET), .ZONE_AUTH(ZONE_AUTH),
        .ZONE_AUTH_KEY(ZONE_AUTH_KEY), .ZONE_ENC(ZONE_ENC),
        .ZONE_ENC_KEY(ZONE_ENC_KEY)
    ) u_grant (
        .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_idx(pw_idx),
        .pw_is_wr(pw_is_wr), .auth_valid(auth_valid), .auth_key(auth_key),
        .mode_i(mode_w), .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    // Mode output as a plain vector.
    always_comb mode = mode_w;

    AST_RESET_STD: assert property (@(posedge clk)
        !rst_n |=> (mode == 2'd0)); // R1
    AST_CARD_RST_STD: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> (mode == 2'd0)); // R9
    AST_AUTH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (au_try && au_accept) |=> (mode == 2'd1)); // R2
endmodule

// File: tb/tb_sess_priv_tracker.sv
`timescale 1ns/1ps
module tb_sess_priv_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0, card_rst = 1'b0;
    logic pw_ok = 1'b0, pw_fail = 1'b0, pw_wr = 1'b0;
    logic [2:0] pw_set = '0;
    logic au_ok = 1'b0, au_fail = 1'b0;
    logic [1:0] au_key = '0;
    logic enc_go = 1'b0, mac_bad = 1'b0;
    logic [1:0] mode;
    logic [3:0] rd_grant, wr_grant;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sess_priv_tracker dut (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .pw_ok(pw_ok),
        .pw_fail(pw_fail), .pw_set(pw_set), .pw_wr(pw_wr), .au_ok(au_ok),
        .au_fail(au_fail), .au_key(au_key), .enc_go(enc_go),
        .mac_bad(mac_bad), .mode(mode), .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [1:0] m,
                             input logic [3:0] rd, input logic [3:0] wr);
        chk({tag, " mode"}, 32'(mode), 32'(m));
        chk({tag, " rd"}, 32'(rd_grant), 32'(rd));
        chk({tag, " wr"}, 32'(wr_grant), 32'(wr));
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic pw(input bit ok, input int s, input bit w);
        @(negedge clk) begin pw_ok = ok; pw_fail = !ok; pw_set = 3'(s); pw_wr = w; end
        @(negedge clk) begin pw_ok = 1'b0; pw_fail = 1'b0; end
    endtask

    task automatic au(input bit ok, input int k);
        @(negedge clk) begin au_ok = ok; au_fail = !ok; au_key = 2'(k); end
        @(negedge clk) begin au_ok = 1'b0; au_fail = 1'b0; end
    endtask

    task automatic enc();
        @(negedge clk) enc_go = 1'b1;
        @(negedge clk) enc_go = 1'b0;
    endtask

    task automatic mac();
        @(negedge clk) mac_bad = 1'b1;
        @(negedge clk) mac_bad = 1'b0;
    endtask

    task automatic crst();
        @(negedge clk) card_rst = 1'b1;
        @(negedge clk) card_rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_state("R1 reset", 2'd0, 4'b0011, 4'b0001);
    endtask

    task automatic t_passwords();
        @(negedge clk) begin pw_ok = 1'b1; pw_set = 3'd1; pw_wr = 1'b1; end
        #1 chk("R10 no change before edge", 32'(wr_grant), 32'h1);
        @(negedge clk) pw_ok = 1'b0;
        chk_state("R5 write pw set1", 2'd0, 4'b0011, 4'b0011);
        pw(1, 3, 0);
        chk_state("R4 read pw set3 replaces", 2'd0, 4'b0011, 4'b0001);
    endtask

    task automatic t_auth();
        au(1, 2);
        chk_state("R2 auth key2", 2'd1, 4'b0111, 4'b0001);
        pw(1, 3, 1);
        chk_state("R5 write pw set3", 2'd1, 4'b0111, 4'b0101);
    endtask

    task automatic t_encrypt();
        enc();
        chk_state("R6 enc wrong key", 2'd2, 4'b0111, 4'b0101);
        au(1, 1);
        chk_state("R2 reauth drops enc", 2'd1, 4'b0011, 4'b0001);
        enc();
        chk_state("R6 enc zone granted", 2'd2, 4'b1011, 4'b1001);
    endtask

    task automatic t_mac();
        mac();
        chk_state("R7 mac revokes", 2'd0, 4'b0011, 4'b0001);
        mac();
        chk_state("R7 mac in std", 2'd0, 4'b0011, 4'b0001);
        au(1, 2);
        chk_state("R7 password kept", 2'd1, 4'b0111, 4'b0101);
    endtask

    task automatic t_enc_std();
        crst();
        chk_state("R9 card reset", 2'd0, 4'b0011, 4'b0001);
        enc();
        chk_state("R3 enc ignored in std", 2'd0, 4'b0011, 4'b0001);
    endtask

    task automatic t_auth_fail();
        au(1, 2);
        chk("R2 auth pass", 32'(mode), 32'd1);
        au(0, 2);
        pw(1, 3, 1);
        chk_state("R2 failed reauth cancels", 2'd0, 4'b0011, 4'b0001);
    endtask

    task automatic t_pw_fail();
        pw(1, 1, 1);
        chk("R4 pw accepted", 32'(wr_grant), 32'h3);
        pw(0, 1, 1);
        chk("R4 pw fail drops", 32'(wr_grant), 32'h1);
    endtask

    task automatic t_pw_limit();
        pw(0, 1, 1); pw(0, 1, 1);
        pw(1, 1, 1);
        chk("R8 pass below limit", 32'(wr_grant), 32'h3);
        for (int i = 0; i < 4; i++) pw(0, 1, 1);
        pw(1, 1, 1);
        chk("R8 pw locked", 32'(wr_grant), 32'h1);
        pw(1, 1, 1);
        chk("R8 pw stays locked", 32'(wr_grant), 32'h1);
        au(1, 2);
        pw(1, 3, 1);
        chk("R8 other set unaffected", 32'(wr_grant), 32'h5);
    endtask

    task automatic t_au_limit();
        for (int i = 0; i < 4; i++) au(0, 1);
        au(1, 1);
        chk("R8 auth key1 locked", 32'(mode), 32'd0);
        au(1, 3);
        chk("R8 other key unaffected", 32'(mode), 32'd1);
    endtask

    task automatic t_card_keeps();
        crst();
        au(1, 1);
        chk("R9 auth lock kept", 32'(mode), 32'd0);
        pw(1, 1, 1);
        chk("R9 pw lock kept", 32'(wr_grant), 32'h1);
    endtask

    task automatic t_power_clear();
        do_reset();
        pw(1, 1, 1);
        chk("R1 pw counter cleared", 32'(wr_grant), 32'h3);
        au(1, 1);
        chk("R1 auth counter cleared", 32'(mode), 32'd1);
    endtask

    initial begin
        t_reset();
        t_passwords();
        t_auth();
        t_encrypt();
        t_mac();
        t_enc_std();
        t_auth_fail();
        t_pw_fail();
        t_pw_limit();
        t_au_limit();
        t_card_keeps();
        t_power_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule